// File: doc/BRIEF.md
# Sixteen-Operation ALU with Spill Register

This block is the arithmetic core of a small 16-bit processor. A 4-bit operation code selects one of sixteen functions of a source operand A and a destination operand B: bitwise logic, negation, shifts, byte manipulation, page masking, add, subtract, multiply, a sequential divide, and an add-back of the spill register. A signed-mode input changes the right shift, the add overflow rule and the multiply.

Beside the result, the block keeps a 16-bit spill register. It holds whatever does not fit in the result: bits shifted out, the high half of a product, a divide remainder, or a carry marker. Operation 0xF adds this register to A, so multi-word arithmetic can be chained. The 3-bit flag vector and the spill register change only on a clock edge where the update strobe is high, or when a divide that was launched with the strobe finishes. All operations except divide give their result combinationally. Divide is a restoring divider that runs for one cycle per bit, with a start input, a busy output and a one-cycle done pulse.

Top module: `alu16_ovr`

## Requirements
- R1: Codes 0x0..0x4 give ~A, A&B, A|B, A^B and the two's-complement negation of A. They set the overflow flag to 0 and load 0 into the spill register.
- R2: The flag vector is bit 2 = result bit 15, bit 1 = result equal to zero, bit 0 = overflow. It is registered on the clock edge where `upd_i` is high and no divide is running.
- R3: Code 0x5 gives B shifted left by A with zero fill. The spill register gets bits 31..16 of the 32-bit shifted value. A shift of 32 or more gives 0 in both.
- R4: Code 0x6 gives B shifted right by A. The shift is arithmetic when `signed_i` is 1 and logical when it is 0. The spill register gets the low A bits of B, which are the bits shifted out. A shift of 16 or more gives 0, or the sign fill, and all of B goes to the spill register.
- R5: Code 0x7 swaps the two bytes of A. Code 0x8 clears the low byte of A. Code 0x9 clears the high byte of A. Code 0xE gives A AND 0xFFC0, which is the base of a 64-word page. All four load 0 into the spill register.
- R6: Code 0xA gives B+A and code 0xB gives B+(−A). In unsigned mode the overflow flag is the carry out of bit 15. In signed mode it is set when B and the addend have the same sign and the sign of the result differs. The spill register gets 1 when the flag is set and 0 when it is not.
- R7: Code 0xC multiplies, signed or unsigned according to `signed_i`. The result is the low half of the product and the spill register gets the high half. The overflow flag is 0 only when the high half is all copies of result bit 15.
- R8: Code 0xF gives A plus the current spill register. It then clears the spill register and the overflow flag.
- R9: When `upd_i` is low, and also while a divide is running, the flags and the spill register do not change.
- R10: Code 0xD gives the unsigned quotient B/A on `result_o`, and the spill register gets the remainder. A divisor of zero gives a quotient of 0xFFFF, a spill of B and the overflow flag set.
- R11: A start with code 0xD while idle raises `busy_o` on the next cycle. `done_o` pulses for one cycle, 16 clock edges after the start edge. The quotient then stays on `result_o` while the code remains 0xD.
- R12: While `rst_n` is low, the flags, the spill register, `busy_o` and `done_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 4 | Operation code |
| src_a_i | input | 16 | Source operand A |
| dst_b_i | input | 16 | Destination operand B |
| signed_i | input | 1 | Signed mode |
| upd_i | input | 1 | Update strobe for flags and spill register |
| start_i | input | 1 | Launches a divide when `op_i` is 0xD |
| result_o | output | 16 | Result |
| flags_o | output | 3 | Registered flags {negative, zero, overflow} |
| ovr_o | output | 16 | Spill register |
| busy_o | output | 1 | Divide in progress |
| done_o | output | 1 | One-cycle pulse when the divide completes |

## Verification
The hardest case to reach from the ports is an update strobe that arrives while a divide is running. Its effect is hidden because the divide overwrites the flags when it finishes. The stimulus therefore launches a divide, switches to a logic operation whose flags would differ, and raises the strobe for one edge. It checks the flags right after that edge, before the divide completes. Spill chaining is reached by a multiply that leaves a known high half, followed by two add-back operations: the first shows the spill being used and the second shows it cleared.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

    typedef enum logic [3:0] {
        OP_NOT  = 4'h0,
        OP_AND  = 4'h1,
        OP_OR   = 4'h2,
        OP_XOR  = 4'h3,
        OP_NEG  = 4'h4,
        OP_SHL  = 4'h5,
        OP_SHR  = 4'h6,
        OP_SWAP = 4'h7,
        OP_ZLO  = 4'h8,
        OP_ZHI  = 4'h9,
        OP_ADD  = 4'hA,
        OP_SUB  = 4'hB,
        OP_MUL  = 4'hC,
        OP_DIV  = 4'hD,
        OP_PAGE = 4'hE,
        OP_ADDO = 4'hF
    } alu_op_e;

    localparam int FLAG_OVF = 0;
    localparam int FLAG_ZERO = 1;
    localparam int FLAG_NEG = 2;
    localparam int FLAG_W = 3;

endpackage

// File: rtl/alu16_ovr_logic.sv
module alu16_ovr_logic
    import alu16_pkg::*;
#(
    parameter int W = 16,
    parameter int PAGE_BITS = 6
) (
    input  alu_op_e      op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         signed_i,
    input  logic [W-1:0] ovr_i,
    output logic [W-1:0] res_o,
    output logic         ovf_o,
    output logic [W-1:0] ovr_o
);

    localparam int HALF = W / 2;
    localparam int LSH = $clog2(2 * W);
    localparam int RSH = $clog2(W) + 1;
    localparam logic [W-1:0] PAGE_MASK = ~((W'(1) << PAGE_BITS) - W'(1));

    logic [2*W-1:0] shl_ext;
    logic [RSH-1:0] rsh_amt;
    logic [W:0]     rsh_one;
    logic [W-1:0]   rsh_mask;
    logic [W-1:0]   addend;
    logic [W:0]     sum;
    logic [2*W-1:0] mul_a;
    logic [2*W-1:0] mul_b;
    logic [2*W-1:0] prod;
    logic           add_sovf;

    always_comb begin
        shl_ext  = (a_i < W'(2 * W)) ? ({{W{1'b0}}, b_i} << a_i[LSH-1:0]) : '0;
        rsh_amt  = (a_i < W'(W)) ? a_i[RSH-1:0] : RSH'(W);
        rsh_one  = (W+1)'(1) << rsh_amt;
        rsh_mask = rsh_one[W-1:0] - W'(1);
        addend   = (op_i == OP_SUB) ? (~a_i + W'(1)) : a_i;
        sum      = {1'b0, b_i} + {1'b0, addend};
        add_sovf = (addend[W-1] == b_i[W-1]) && (sum[W-1] != b_i[W-1]);
        mul_a    = signed_i ? {{W{a_i[W-1]}}, a_i} : {{W{1'b0}}, a_i};
        mul_b    = signed_i ? {{W{b_i[W-1]}}, b_i} : {{W{1'b0}}, b_i};
        prod     = mul_a * mul_b;
    end

    always_comb begin
        res_o = '0;
        ovf_o = 1'b0;
        ovr_o = '0;
        unique case (op_i)
            OP_NOT:  res_o = ~a_i;
            OP_AND:  res_o = a_i & b_i;
            OP_OR:   res_o = a_i | b_i;
            OP_XOR:  res_o = a_i ^ b_i;
            OP_NEG:  res_o = ~a_i + W'(1);
            OP_SHL: begin
                res_o = shl_ext[W-1:0];
                ovr_o = shl_ext[2*W-1:W];
            end
            OP_SHR: begin
                res_o = signed_i ? $unsigned($signed(b_i) >>> rsh_amt) : (b_i >> rsh_amt);
                ovr_o = b_i & rsh_mask;
            end
            OP_SWAP: res_o = {a_i[HALF-1:0], a_i[W-1:HALF]};
            OP_ZLO:  res_o = {a_i[W-1:HALF], {HALF{1'b0}}};
            OP_ZHI:  res_o = {{(W-HALF){1'b0}}, a_i[HALF-1:0]};
            OP_ADD, OP_SUB: begin
                res_o = sum[W-1:0];
                ovf_o = signed_i ? add_sovf : sum[W];
                ovr_o = {{(W-1){1'b0}}, ovf_o};
            end
            OP_MUL: begin
                res_o = prod[W-1:0];
                ovr_o = prod[2*W-1:W];
                ovf_o = prod[2*W-1:W] != {W{prod[W-1]}};
            end
            OP_DIV:  res_o = '0;
            OP_PAGE: res_o = a_i & PAGE_MASK;
            OP_ADDO: res_o = a_i + ovr_i;
            default: res_o = '0;
        endcase
    end

endmodule

// File: rtl/alu16_ovr_div.sv
module alu16_ovr_div #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [W-1:0] dividend_i,
    input  logic [W-1:0] divisor_i,
    output logic         busy_o,
    output logic         done_o,
    output logic         last_o,
    output logic         dz_o,
    output logic [W-1:0] quo_o,
    output logic [W-1:0] quo_nxt_o,
    output logic [W-1:0] rem_nxt_o
);

    localparam int CW = $clog2(W + 1);

    typedef struct packed {
        logic         busy;
        logic         done;
        logic [CW-1:0] cnt;
        logic [W-1:0] rem;
        logic [W-1:0] quo;
        logic [W-1:0] div;
    } div_state_t;

    div_state_t st_d, st_q;
    logic [W:0]   trial;
    logic [W:0]   diff;
    logic         qbit;
    logic [W-1:0] rem_step;
    logic [W-1:0] quo_step;

    always_comb begin
        trial    = {st_q.rem, st_q.quo[W-1]};
        diff     = trial - {1'b0, st_q.div};
        qbit     = trial >= {1'b0, st_q.div};
        rem_step = qbit ? diff[W-1:0] : trial[W-1:0];
        quo_step = {st_q.quo[W-2:0], qbit};

        st_d      = st_q;
        st_d.done = 1'b0;
        if (start_i && !st_q.busy) begin
            st_d.busy = 1'b1;
            st_d.cnt  = CW'(W);
            st_d.rem  = '0;
            st_d.quo  = dividend_i;
            st_d.div  = divisor_i;
        end else if (st_q.busy) begin
            st_d.rem = rem_step;
            st_d.quo = quo_step;
            st_d.cnt = st_q.cnt - CW'(1);
            if (st_q.cnt == CW'(1)) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o    = st_q.busy;
    assign done_o    = st_q.done;
    assign last_o    = st_q.busy && (st_q.cnt == CW'(1));
    assign dz_o      = st_q.div == '0;
    assign quo_o     = st_q.quo;
    assign quo_nxt_o = quo_step;
    assign rem_nxt_o = rem_step;

endmodule

// File: rtl/alu16_ovr.sv
module alu16_ovr
    import alu16_pkg::*;
#(
    parameter int W = 16,
    parameter int PAGE_BITS = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [3:0]   op_i,
    input  logic [W-1:0] src_a_i,
    input  logic [W-1:0] dst_b_i,
    input  logic         signed_i,
    input  logic         upd_i,
    input  logic         start_i,
    output logic [W-1:0] result_o,
    output logic [FLAG_W-1:0] flags_o,
    output logic [W-1:0] ovr_o,
    output logic         busy_o,
    output logic         done_o
);

    typedef struct packed {
        logic [FLAG_W-1:0] flags;
        logic [W-1:0]      ovr;
        logic              pend;
    } top_state_t;

    top_state_t st_d, st_q;
    alu_op_e      op;
    logic [W-1:0] lg_res;
    logic         lg_ovf;
    logic [W-1:0] lg_ovr;
    logic         div_start;
    logic         div_busy;
    logic         div_done;
    logic         div_last;
    logic         div_dz;
    logic [W-1:0] div_quo;
    logic [W-1:0] div_quo_nxt;
    logic [W-1:0] div_rem_nxt;

    assign op        = alu_op_e'(op_i);
    assign div_start = start_i && (op == OP_DIV) && !div_busy;

    alu16_ovr_logic #(.W(W), .PAGE_BITS(PAGE_BITS)) u_logic (
        .op_i    (op),
        .a_i     (src_a_i),
        .b_i     (dst_b_i),
        .signed_i(signed_i),
        .ovr_i   (st_q.ovr),
        .res_o   (lg_res),
        .ovf_o   (lg_ovf),
        .ovr_o   (lg_ovr)
    );

    alu16_ovr_div #(.W(W)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (div_start),
        .dividend_i(dst_b_i),
        .divisor_i (src_a_i),
        .busy_o    (div_busy),
        .done_o    (div_done),
        .last_o    (div_last),
        .dz_o      (div_dz),
        .quo_o     (div_quo),
        .quo_nxt_o (div_quo_nxt),
        .rem_nxt_o (div_rem_nxt)
    );

    always_comb begin
        st_d = st_q;
        if (div_start) begin
            st_d.pend = upd_i;
        end
        if (div_last) begin
            if (st_q.pend) begin
                st_d.flags[FLAG_NEG]  = div_quo_nxt[W-1];
                st_d.flags[FLAG_ZERO] = div_quo_nxt == '0;
                st_d.flags[FLAG_OVF]  = div_dz;
                st_d.ovr              = div_rem_nxt;
            end
            st_d.pend = 1'b0;
        end else if (!div_busy && upd_i && (op != OP_DIV)) begin
            st_d.flags[FLAG_NEG]  = lg_res[W-1];
            st_d.flags[FLAG_ZERO] = lg_res == '0;
            st_d.flags[FLAG_OVF]  = lg_ovf;
            st_d.ovr              = lg_ovr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign result_o = (op == OP_DIV) ? div_quo : lg_res;
    assign flags_o  = st_q.flags;
    assign ovr_o    = st_q.ovr;
    assign busy_o   = div_busy;
    assign done_o   = div_done;

endmodule

// File: rtl/alu16_ovr_chk.sv
module alu16_ovr_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic [3:0]   op_i,
    input logic         upd_i,
    input logic         start_i,
    input logic [W-1:0] result_o,
    input logic [2:0]   flags_o,
    input logic [W-1:0] ovr_o,
    input logic         busy_o,
    input logic         done_o
);

    // R12
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |-> (flags_o == '0 && ovr_o == '0 && !busy_o && !done_o));

    // R11
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && op_i == 4'hD && !busy_o) |=> busy_o);

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R11
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_i && !busy_o) |=> ($stable(flags_o) && $stable(ovr_o)));

    // R2
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && !busy_o && op_i != 4'hD) |=> (flags_o[1] == ($past(result_o) == '0)));

    // R2
    neg_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && !busy_o && op_i != 4'hD) |=> (flags_o[2] == $past(result_o[W-1])));

endmodule

bind alu16_ovr alu16_ovr_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_i    (op_i),
    .upd_i   (upd_i),
    .start_i (start_i),
    .result_o(result_o),
    .flags_o (flags_o),
    .ovr_o   (ovr_o),
    .busy_o  (busy_o),
    .done_o  (done_o)
);

// File: tb/alu16_ovr_bench.sv
`timescale 1ns/1ps
module alu16_ovr_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op_i = 4'h0;
    logic [15:0] src_a_i = '0;
    logic [15:0] dst_b_i = '0;
    logic        signed_i = 1'b0;
    logic        upd_i = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] result_o;
    logic [2:0]  flags_o;
    logic [15:0] ovr_o;
    logic        busy_o;
    logic        done_o;

    int total = 0;
    int fails = 0;
    logic [2:0] last_flags = 3'b000;

    always #2.5 clk = ~clk;

    alu16_ovr u_alu16_ovr (
        .clk     (clk),
        .rst_n   (rst_n),
        .op_i    (op_i),
        .src_a_i (src_a_i),
        .dst_b_i (dst_b_i),
        .signed_i(signed_i),
        .upd_i   (upd_i),
        .start_i (start_i),
        .result_o(result_o),
        .flags_o (flags_o),
        .ovr_o   (ovr_o),
        .busy_o  (busy_o),
        .done_o  (done_o)
    );

    task automatic chk(input string req, input string what, input logic [15:0] got, input logic [15:0] exp);
        total++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic run_op(input string req, input logic [3:0] op, input logic [15:0] a,
                          input logic [15:0] b, input logic sgn, input logic upd,
                          input logic [15:0] eres, input logic [2:0] efl, input logic [15:0] eovr);
        @(negedge clk);
        op_i = op; src_a_i = a; dst_b_i = b; signed_i = sgn; upd_i = upd; start_i = 1'b0;
        #1;
        chk(req, "result", result_o, eres);
        @(posedge clk);
        #1;
        chk(req, "flags", {13'b0, flags_o}, {13'b0, efl});
        chk(req, "spill", ovr_o, eovr);
        @(negedge clk);
        upd_i = 1'b0;
        if (upd) last_flags = efl;
    endtask

    task automatic t_reset();
        repeat (3) @(posedge clk);
        #1;
        chk("R12", "flags", {13'b0, flags_o}, 16'h0);
        chk("R12", "spill", ovr_o, 16'h0);
        chk("R12", "busy/done", {14'b0, busy_o, done_o}, 16'h0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_logic();
        run_op("R1", 4'h0, 16'h00F0, 16'h0000, 1'b0, 1'b1, 16'hFF0F, 3'b100, 16'h0);
        run_op("R1", 4'h1, 16'h0F0F, 16'h00FF, 1'b0, 1'b1, 16'h000F, 3'b000, 16'h0);
        run_op("R1", 4'h2, 16'h0F00, 16'h00F0, 1'b0, 1'b1, 16'h0FF0, 3'b000, 16'h0);
        run_op("R2", 4'h3, 16'hAAAA, 16'hAAAA, 1'b0, 1'b1, 16'h0000, 3'b010, 16'h0);
        run_op("R1", 4'h4, 16'h0001, 16'h0000, 1'b0, 1'b1, 16'hFFFF, 3'b100, 16'h0);
    endtask

    task automatic t_shifts();
        run_op("R3", 4'h5, 16'd4,  16'h1234, 1'b0, 1'b1, 16'h2340, 3'b000, 16'h0001);
        run_op("R3", 4'h5, 16'd20, 16'h00F1, 1'b0, 1'b1, 16'h0000, 3'b010, 16'h0F10);
        run_op("R3", 4'h5, 16'd40, 16'hFFFF, 1'b0, 1'b1, 16'h0000, 3'b010, 16'h0000);
        run_op("R4", 4'h6, 16'd4,  16'h8123, 1'b0, 1'b1, 16'h0812, 3'b000, 16'h0003);
        run_op("R4", 4'h6, 16'd4,  16'h8123, 1'b1, 1'b1, 16'hF812, 3'b100, 16'h0003);
        run_op("R4", 4'h6, 16'd18, 16'h9000, 1'b1, 1'b1, 16'hFFFF, 3'b100, 16'h9000);
        run_op("R4", 4'h6, 16'd16, 16'h9000, 1'b0, 1'b1, 16'h0000, 3'b010, 16'h9000);
    endtask

    task automatic t_bytes();
        run_op("R5", 4'h7, 16'h12AB, 16'h0000, 1'b0, 1'b1, 16'hAB12, 3'b100, 16'h0);
        run_op("R5", 4'h8, 16'h12AB, 16'h0000, 1'b0, 1'b1, 16'h1200, 3'b000, 16'h0);
        run_op("R5", 4'h9, 16'h12AB, 16'h0000, 1'b0, 1'b1, 16'h00AB, 3'b000, 16'h0);
        run_op("R5", 4'hE, 16'h12AB, 16'h0000, 1'b0, 1'b1, 16'h1280, 3'b000, 16'h0);
    endtask

    task automatic t_addsub();
        run_op("R6", 4'hA, 16'h0001, 16'hFFFF, 1'b0, 1'b1, 16'h0000, 3'b011, 16'h0001);
        run_op("R6", 4'hA, 16'h7000, 16'h1000, 1'b1, 1'b1, 16'h8000, 3'b101, 16'h0001);
        run_op("R6", 4'hA, 16'h7000, 16'h1000, 1'b0, 1'b1, 16'h8000, 3'b100, 16'h0000);
        run_op("R6", 4'hB, 16'h0003, 16'h0005, 1'b0, 1'b1, 16'h0002, 3'b001, 16'h0001);
        run_op("R6", 4'hB, 16'h0001, 16'h8000, 1'b1, 1'b1, 16'h7FFF, 3'b001, 16'h0001);
    endtask

    task automatic t_mul_chain();
        run_op("R7", 4'hC, 16'h0100, 16'h0234, 1'b0, 1'b1, 16'h3400, 3'b001, 16'h0002);
        run_op("R7", 4'hC, 16'hFFFF, 16'h0005, 1'b1, 1'b1, 16'hFFFB, 3'b100, 16'hFFFF);
        run_op("R7", 4'hC, 16'hFFFF, 16'h0005, 1'b0, 1'b1, 16'hFFFB, 3'b101, 16'h0004);
        run_op("R8", 4'hF, 16'h0010, 16'h0000, 1'b0, 1'b1, 16'h0014, 3'b000, 16'h0000);
        run_op("R8", 4'hF, 16'h0010, 16'h0000, 1'b0, 1'b1, 16'h0010, 3'b000, 16'h0000);
    endtask

    task automatic t_hold();
        run_op("R9", 4'h5, 16'd4, 16'h1234, 1'b0, 1'b1, 16'h2340, 3'b000, 16'h0001);
        run_op("R9", 4'h0, 16'h0000, 16'h0000, 1'b0, 1'b0, 16'hFFFF, 3'b000, 16'h0001);
        run_op("R9", 4'hF, 16'h0000, 16'h0000, 1'b0, 1'b0, 16'h0001, 3'b000, 16'h0001);
    endtask

    task automatic run_div(input logic [15:0] a, input logic [15:0] b, input logic [15:0] eq,
                           input logic [15:0] er, input logic [2:0] efl, input logic poke);
        int n;
        @(negedge clk);
        op_i = 4'hD; src_a_i = a; dst_b_i = b; signed_i = 1'b0; upd_i = 1'b1; start_i = 1'b1;
        @(posedge clk);
        #1;
        chk("R11", "busy after start", {15'b0, busy_o}, 16'h1);
        n = 0;
        @(negedge clk);
        start_i = 1'b0; upd_i = 1'b0;
        if (poke) begin
            op_i = 4'h1; src_a_i = 16'h0; dst_b_i = 16'h0; upd_i = 1'b1;
            @(posedge clk);
            #1;
            n++;
            chk("R9", "flags while busy", {13'b0, flags_o}, {13'b0, last_flags});
            @(negedge clk);
            upd_i = 1'b0; op_i = 4'hD;
        end
        while (!done_o && n < 40) begin
            @(posedge clk);
            #1;
            n++;
        end
        chk("R11", "edges to done", 16'(n), 16'd16);
        chk("R10", "quotient", result_o, eq);
        chk("R10", "remainder", ovr_o, er);
        chk("R10", "flags", {13'b0, flags_o}, {13'b0, efl});
        @(posedge clk);
        #1;
        chk("R11", "done pulse width", {15'b0, done_o}, 16'h0);
        chk("R11", "quotient held", result_o, eq);
        last_flags = efl;
    endtask

    task automatic t_div();
        run_div(16'd7, 16'd100, 16'h000E, 16'h0002, 3'b000, 1'b1);
        run_div(16'h0100, 16'hFFFF, 16'h00FF, 16'h00FF, 3'b000, 1'b0);
        run_div(16'h0000, 16'h1234, 16'hFFFF, 16'h1234, 3'b101, 1'b0);
    endtask

    initial begin
        t_reset();
        t_logic();
        t_shifts();
        t_bytes();
        t_addsub();
        t_mul_chain();
        t_hold();
        t_div();
        repeat (2) @(posedge clk);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule